// File: doc/BRIEF.md
# Receive Address Filter CAM

This block makes the accept or reject decision for the 48-bit destination address of an incoming frame, and it marks accepted frames as broadcast or multicast when a class rule admitted them. Three mode inputs enable the class rules: promiscuous, accept-all-multicast and broadcast-accept. The rules are checked in a fixed priority order. If none of them admits the address, it is compared against a small exact-match memory. Each entry of that memory has an enable bit in a mask, and an entry takes part in the comparison only while its bit is set.

A load engine fills the memory and the mask from a stream of 16-bit descriptor words that are already fetched. Software starts a load with an entry count. While software holds the surrounding controller in reset mode, it can read every stored entry back through a pointer-and-select port.

Top module: `rx_addr_cam`

## Requirements
- R1: When `da_valid` is high, promiscuous mode is on and bit 0 of byte 0 (`da[0]`) is 0, the address is accepted with both tag outputs low. This rule has the highest priority.
- R2: Otherwise, when accept-all-multicast is on and `da[0]` is 1, the address is accepted with `tag_mcast` high. This also covers an all-ones address.
- R3: Otherwise, when broadcast-accept is on and all 48 address bits are 1, the address is accepted with `tag_bcast` high.
- R4: Otherwise, the address is accepted with no tag only if an entry whose `enable_mask` bit is 1 equals the whole address. In all other cases `accept` is 0 and both tags are 0.
- R5: Each entry descriptor on the word stream is four words long. Word 0 is discarded. Words 1, 2 and 3 carry address bytes 0–1, 2–3 and 4–5, with the lower-numbered byte in bits 7:0, so the stored entry equals `da` bit for bit.
- R6: A `load_start` pulse while idle loads `load_count` entry descriptors into entries 0, 1, 2 and so on. The index wraps modulo the entry count, and a count of 0 loads no entries. A `load_start` pulse while `load_busy` is high is ignored.
- R7: After the entry descriptors, one more four-word descriptor follows, and its word 0 becomes `enable_mask`. On the cycle after the last word of that descriptor, `load_busy` is low and `load_done` is high for exactly one cycle.
- R8: While `reset_mode` is high, `rd_data` returns entry `rd_ptr` as bytes 0–1, 2–3 or 4–5 for `rd_sel` = 0, 1 or 2, with the lower-numbered byte in bits 7:0. For `rd_sel` = 3, and at all times while `reset_mode` is low, `rd_data` is 0.
- R9: The filter outputs update on the clock edge that samples `da_valid` high, and they hold their values until the next strobe.
- R10: After reset, `enable_mask`, all entries, the filter outputs, `load_busy` and `load_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_mode | input | 1 | Controller is in software reset mode; gates readback |
| cfg_promisc | input | 1 | Promiscuous rule enable |
| cfg_all_mcast | input | 1 | Accept-all-multicast rule enable |
| cfg_bcast | input | 1 | Broadcast rule enable |
| load_start | input | 1 | Start a load sequence |
| load_count | input | CNT_W | Number of entry descriptors to load |
| ld_valid | input | 1 | Descriptor word present |
| ld_word | input | 16 | Descriptor word |
| load_busy | output | 1 | Load sequence in progress |
| load_done | output | 1 | One-cycle load-complete pulse |
| enable_mask | output | ENTRIES | Per-entry match enable |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| accept | output | 1 | Address accepted |
| tag_bcast | output | 1 | Accepted by the broadcast rule |
| tag_mcast | output | 1 | Accepted by the all-multicast rule |
| rd_ptr | input | IDX_W | Entry selected for readback |
| rd_sel | input | 2 | Byte-pair selector for readback |
| rd_data | output | 16 | Readback data |

## Verification
The assertions take for granted that `da` is stable in every cycle where `da_valid` is high. They also take for granted that descriptor words arrive only while a load is running, so a stray word never has to be ignored. The stimulus changes `da` only together with the strobe, and it sends words only between a start pulse and the completion pulse, with idle gaps between words. The one exception is a deliberate second start pulse in the middle of a load. The stimulus also keeps the mode inputs steady around every strobe, so each rule decision comes from one known configuration.

// File: rtl/rx_addr_cam.sv
module rx_addr_cam #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_mode,
  input  logic               cfg_promisc,
  input  logic               cfg_all_mcast,
  input  logic               cfg_bcast,
  input  logic               load_start,
  input  logic [CNT_W-1:0]   load_count,
  input  logic               ld_valid,
  input  logic [15:0]        ld_word,
  output logic               load_busy,
  output logic               load_done,
  output logic [ENTRIES-1:0] enable_mask,
  input  logic               da_valid,
  input  logic [47:0]        da,
  output logic               accept,
  output logic               tag_bcast,
  output logic               tag_mcast,
  input  logic [IDX_W-1:0]   rd_ptr,
  input  logic [1:0]         rd_sel,
  output logic [15:0]        rd_data
);

  logic [47:0]        cam_q [ENTRIES];
  logic [CNT_W-1:0]   remain;
  logic [IDX_W-1:0]   idx;
  logic [1:0]         pos;
  logic [ENTRIES-1:0] hits;

  wire take      = load_busy && ld_valid;
  wire mask_step = (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) cam_q[i] <= '0;
      enable_mask <= '0;
      load_busy   <= 1'b0;
      load_done   <= 1'b0;
      remain      <= '0;
      idx         <= '0;
      pos         <= '0;
    end else begin
      load_done <= take && mask_step && (pos == 2'd3);
      if (load_start && !load_busy) begin
        load_busy <= 1'b1;
        remain    <= load_count;
        idx       <= '0;
        pos       <= '0;
      end else if (take) begin
        pos <= pos + 2'd1;
        if (!mask_step) begin
          case (pos)
            2'd1: cam_q[idx][15:0]  <= ld_word;
            2'd2: cam_q[idx][31:16] <= ld_word;
            2'd3: begin
              cam_q[idx][47:32] <= ld_word;
              remain <= remain - 1'b1;
              idx    <= idx + 1'b1;
            end
            default: ;
          endcase
        end else begin
          if (pos == 2'd0) enable_mask <= ld_word[ENTRIES-1:0];
          if (pos == 2'd3) load_busy <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = enable_mask[g] && (cam_q[g] == da);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept    <= 1'b0;
      tag_bcast <= 1'b0;
      tag_mcast <= 1'b0;
    end else if (da_valid) begin
      tag_bcast <= 1'b0;
      tag_mcast <= 1'b0;
      if (cfg_promisc && !da[0])      accept <= 1'b1;
      else if (cfg_all_mcast && da[0]) begin accept <= 1'b1; tag_mcast <= 1'b1; end
      else if (cfg_bcast && &da)       begin accept <= 1'b1; tag_bcast <= 1'b1; end
      else                             accept <= |hits;
    end
  end

  always_comb begin
    rd_data = '0;
    if (reset_mode) begin
      case (rd_sel)
        2'd0: rd_data = cam_q[rd_ptr][15:0];
        2'd1: rd_data = cam_q[rd_ptr][31:16];
        2'd2: rd_data = cam_q[rd_ptr][47:32];
        default: rd_data = '0;
      endcase
    end
  end

  a_r1_promisc_unicast: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cfg_promisc && !da[0]) |=> (accept && !tag_bcast && !tag_mcast));

  a_r2_all_mcast: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cfg_all_mcast && da[0]) |=> (accept && tag_mcast && !tag_bcast));

  a_r3_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cfg_bcast && !cfg_all_mcast && (&da)) |=> (accept && tag_bcast && !tag_mcast));

  a_r4_tag_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_bcast || tag_mcast) |-> (accept && $onehot0({tag_bcast, tag_mcast})));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> $stable({accept, tag_bcast, tag_mcast}));

  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    (load_start && !load_busy) |=> load_busy);

  a_r7_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_busy) |-> load_done);

endmodule

// File: tb/tb_rx_addr_cam.sv
module tb_rx_addr_cam;
  localparam int ENTRIES = 16;
  localparam int CNT_W = 5;
  localparam int IDX_W = 4;

  logic clk = 0, rst_n = 0, reset_mode = 0;
  logic cfg_promisc = 0, cfg_all_mcast = 0, cfg_bcast = 0;
  logic load_start = 0, ld_valid = 0, da_valid = 0;
  logic [CNT_W-1:0] load_count = '0;
  logic [15:0] ld_word = '0;
  logic [47:0] da = '0;
  logic [IDX_W-1:0] rd_ptr = '0;
  logic [1:0] rd_sel = '0;
  logic load_busy, load_done, accept, tag_bcast, tag_mcast;
  logic [ENTRIES-1:0] enable_mask;
  logic [15:0] rd_data;

  rx_addr_cam #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
    .cfg_promisc(cfg_promisc), .cfg_all_mcast(cfg_all_mcast), .cfg_bcast(cfg_bcast),
    .load_start(load_start), .load_count(load_count), .ld_valid(ld_valid), .ld_word(ld_word),
    .load_busy(load_busy), .load_done(load_done), .enable_mask(enable_mask),
    .da_valid(da_valid), .da(da), .accept(accept), .tag_bcast(tag_bcast), .tag_mcast(tag_mcast),
    .rd_ptr(rd_ptr), .rd_sel(rd_sel), .rd_data(rd_data));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference model
  byte unsigned m_cam [ENTRIES][6];
  int m_mask = 0, m_busy = 0, m_done = 0, m_left = 0, m_idx = 0, m_pos = 0;
  int m_acc = 0, m_bc = 0, m_mc = 0;
  string m_rule = "R10";

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    if (!reset_mode || rd_sel == 2'd3) return 0;
    return {m_cam[rd_ptr][2*rd_sel+1], m_cam[rd_ptr][2*rd_sel]};
  endfunction

  function automatic void model_match();
    bit unicast, allff, hit;
    unicast = (da[0] == 1'b0);
    allff = 1;
    for (int b = 0; b < 6; b++) if (da[8*b +: 8] != 8'hff) allff = 0;
    m_bc = 0; m_mc = 0;
    if (cfg_promisc && unicast) begin m_acc = 1; m_rule = "R1"; end
    else if (cfg_all_mcast && !unicast) begin m_acc = 1; m_mc = 1; m_rule = "R2"; end
    else if (cfg_bcast && allff) begin m_acc = 1; m_bc = 1; m_rule = "R3"; end
    else begin
      hit = 0;
      for (int e = 0; e < ENTRIES; e++) begin
        bit same = 1;
        for (int b = 0; b < 6; b++) if (m_cam[e][b] != da[8*b +: 8]) same = 0;
        if (same && m_mask[e]) hit = 1;
      end
      m_acc = hit; m_rule = "R4";
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) for (int b = 0; b < 6; b++) m_cam[e][b] = 0;
      m_mask = 0; m_busy = 0; m_done = 0; m_acc = 0; m_bc = 0; m_mc = 0;
    end else begin
      if (da_valid) model_match();
      m_done = 0;
      if (load_start && !m_busy) begin
        m_busy = 1; m_left = load_count; m_idx = 0; m_pos = 0;
      end else if (m_busy && ld_valid) begin
        if (m_left > 0) begin
          if (m_pos > 0) begin
            m_cam[m_idx][2*(m_pos-1)]   = ld_word[7:0];
            m_cam[m_idx][2*(m_pos-1)+1] = ld_word[15:8];
          end
          if (m_pos == 3) begin m_left--; m_idx = (m_idx + 1) % ENTRIES; end
        end else begin
          if (m_pos == 0) m_mask = ld_word;
          if (m_pos == 3) begin m_busy = 0; m_done = 1; end
        end
        m_pos = (m_pos + 1) % 4;
      end
    end
    #1;
    if (rst_n && !finished) begin
      check({m_rule, "/R9 accept"}, accept, m_acc);
      check({m_rule, "/R9 tag_bcast"}, tag_bcast, m_bc);
      check({m_rule, "/R9 tag_mcast"}, tag_mcast, m_mc);
      check("R6 load_busy", load_busy, m_busy);
      check("R7 load_done", load_done, m_done);
      check("R7 enable_mask", enable_mask, m_mask);
      check("R5/R8 rd_data", rd_data, exp_rd());
    end
  end

  logic [47:0] tab [32];

  task automatic send_word(logic [15:0] w, bit gap);
    @(negedge clk); ld_valid = 1; ld_word = w;
    @(negedge clk); ld_valid = 0;
    if (gap) @(negedge clk);
  endtask

  task automatic do_load(int cnt, logic [15:0] mask, bit poke);
    @(negedge clk); load_start = 1; load_count = cnt[CNT_W-1:0];
    @(negedge clk); load_start = 0;
    for (int e = 0; e < cnt; e++) begin
      send_word(16'hdead, e[0]);
      if (poke && e == 0) begin
        load_start = 1; load_count = 5'd9; // R6: ignored while busy
      end
      send_word(tab[e][15:0], 0);
      load_start = 0;
      send_word(tab[e][31:16], 1);
      send_word(tab[e][47:32], 0);
    end
    send_word(mask, 0);
    send_word(16'h1111, 1);
    send_word(16'h2222, 0);
    send_word(16'h3333, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(logic [47:0] a);
    @(negedge clk); da = a; da_valid = 1;
    @(negedge clk); da_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep_read();
    for (int p = 0; p < ENTRIES; p++)
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); rd_ptr = p[IDX_W-1:0]; rd_sel = s[1:0];
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 accept", accept, 0);
    check("R10 load_busy", load_busy, 0);
    check("R10 load_done", load_done, 0);
    check("R10 enable_mask", enable_mask, 0);
    rst_n = 1;
    reset_mode = 1;
    strobe(48'h0);
    check("R10 zero entry not enabled", accept, 0);

    tab[0] = 48'h665544332210; tab[1] = 48'h0b0a09080706; tab[2] = 48'hf0e0d0c0b0a2;
    do_load(3, 16'h0005, 1);
    check("R7 mask loaded", enable_mask, 16'h0005);
    @(negedge clk); rd_ptr = 0; rd_sel = 0;
    #1 check("R8 entry0 bytes0-1", rd_data, 16'h2210);
    @(negedge clk); rd_ptr = 2; rd_sel = 2;
    #1 check("R8 entry2 bytes4-5", rd_data, 16'hf0e0);
    sweep_read();
    reset_mode = 0;
    sweep_read();
    @(negedge clk); rd_ptr = 0; rd_sel = 0;
    #1 check("R8 zero outside reset mode", rd_data, 0);

    strobe(tab[0]);
    check("R4 enabled entry hit", accept, 1);
    strobe(tab[1]);
    check("R4 disabled entry miss", accept, 0);
    strobe(tab[2]);
    strobe(48'h123456789a00);
    check("R4 unknown miss", accept, 0);

    cfg_promisc = 1;
    strobe(48'h123456789a00);
    check("R1 promisc unicast", accept, 1);
    strobe(48'h123456789a01);
    check("R1 promisc multicast falls through", accept, 0);
    cfg_all_mcast = 1;
    strobe(48'h123456789a01);
    check("R2 mcast tag", tag_mcast, 1);
    cfg_bcast = 1;
    strobe(48'hffffffffffff);
    check("R2 all-ones takes mcast tag", tag_mcast, 1);
    cfg_all_mcast = 0;
    strobe(48'hffffffffffff);
    check("R3 bcast tag", tag_bcast, 1);
    cfg_bcast = 0; cfg_promisc = 0;
    strobe(48'hffffffffffff);
    check("R4 all-ones no rule", accept, 0);

    do_load(0, 16'h0002, 0);
    check("R6 zero count mask only", enable_mask, 16'h0002);
    strobe(tab[1]);
    check("R4 entry1 now enabled", accept, 1);

    for (int e = 0; e < 17; e++) tab[e] = {8'h40 + e[7:0], 40'h0504030200} | 48'h100 * e;
    do_load(17, 16'hffff, 0);
    reset_mode = 1;
    sweep_read();
    reset_mode = 0;
    strobe(tab[16]);
    check("R6 wrapped entry0 hit", accept, 1);
    strobe(tab[0]);
    check("R6 overwritten entry0 miss", accept, 0);
    strobe(tab[15]);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule